// File: doc/BRIEF.md
# Strap-Configurable Dual Clock Divider

The block takes one master clock and produces two slower clocks from it: a system clock and a PWM master clock. Each output has its own power-of-two divider with ratios of 1, 2, 4 or 8. An 8-bit configuration register selects both ratios. The same register also holds a driver enable for the system clock and a crystal power-down flag, and both are brought out as pins.

One code of the system-clock divider field does not name a ratio. For that code the ratio comes from a strap pin, and the strap pin is captured once, at the rising edge of the active-low reset. After that capture the pin is free for other uses.

Every divided output has a 50% duty cycle. Each period starts with its high half. A new ratio is accepted only when the running period finishes, so reprogramming the block never cuts a pulse short.

Top module: `dual_clk_divider`

## Requirements
- R1: Register bits 6:5 set the system-clock ratio: code 01 gives ÷2, code 10 gives ÷4 and code 11 gives ÷8.
- R2: While bits 6:5 hold 00, the system-clock ratio is ÷1 if the captured strap was low, and ÷2 if it was high.
- R3: The strap is captured on the rising edge of `rstN`. Later changes on `strapIn` do not change the ratio.
- R4: Register bits 4:3 set the PWM clock ratio: codes 00, 01, 10 and 11 give ÷1, ÷2, ÷4 and ÷8.
- R5: Register bit 7 drives `sysDrvEn`. While this bit is 0, `sysClkOut` is held low.
- R6: Reset sets the register to 8'h80. This means the enable is 1, both divider fields are 00, and the power-down bit and bits 1:0 are 0.
- R7: Register bit 2 appears on `xtalPdn`. A value of 1 means the oscillator is powered down.
- R8: `rdData` returns all 8 written bits unchanged, from the cycle after the write. This includes bits 1:0, which have no other effect.
- R9: At every ratio N above 1, an output period begins with a rising edge. It stays high for N/2 master cycles and then low for N/2 master cycles.
- R10: A ratio written in the middle of a period takes effect only after that period has completed. The first period at the new ratio starts at that boundary with its high half.
- R11: At ratio 1 the output follows the master clock directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset; its rising edge captures the strap |
| strapIn | input | 1 | Strap that selects ÷1 or ÷2 for system-clock code 00 |
| wrEn | input | 1 | Register write strobe, sampled on the rising edge of `mclk` |
| wrData | input | 8 | Register write data |
| rdData | output | 8 | Current register contents |
| sysClkOut | output | 1 | Divided system clock, gated by the enable bit |
| pwmClkOut | output | 1 | Divided PWM master clock |
| sysDrvEn | output | 1 | Enable for the system-clock driver |
| xtalPdn | output | 1 | Crystal power-down flag |

## Verification
The two functions that can meet in one cycle are a register write and the end of an output period. A write that lands on the boundary edge must not be taken by that boundary, and a write that lands mid-period must wait for the next boundary. Random register writes are issued at random distances from one another, so they land at every phase of every ratio on both lanes. At each cycle the sampled outputs are compared with a bench model that loads a new ratio only at the end of a period and starts every period with its high half.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int REG_W        = 8;
  localparam int SHIFT_W      = 2;
  localparam int LANES        = 2;
  localparam int SYS_EN_BIT   = 7;
  localparam int SYS_DIV_LSB  = 5;
  localparam int PWM_DIV_LSB  = 3;
  localparam int XTAL_PDN_BIT = 2;
  localparam logic [REG_W-1:0] REG_RESET = 8'h80;

  // requests from control to the datapath
  typedef struct packed {
    logic [SHIFT_W-1:0] sysShift;
    logic [SHIFT_W-1:0] pwmShift;
    logic               sysGate;
  } laneReq_t;
endpackage

// File: rtl/clkdiv_ctrl.sv
module clkdiv_ctrl
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             strapIn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output laneReq_t         laneReq,
  output logic             sysDrvEn,
  output logic             xtalPdn
);
  logic [REG_W-1:0]   cfgReg;
  logic               strapLatch;
  logic [SHIFT_W-1:0] sysCode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     cfgReg <= REG_RESET;
    else if (wrEn) cfgReg <= wrData;
  end

  // strap captured once, on reset release
  always_ff @(posedge rstN) begin
    strapLatch <= strapIn;
  end

  assign sysCode = cfgReg[SYS_DIV_LSB +: SHIFT_W];

  always_comb begin
    laneReq.sysShift = (sysCode == '0) ? SHIFT_W'(strapLatch) : sysCode;
    laneReq.pwmShift = cfgReg[PWM_DIV_LSB +: SHIFT_W];
    laneReq.sysGate  = cfgReg[SYS_EN_BIT];
  end

  assign rdData   = cfgReg;
  assign sysDrvEn = cfgReg[SYS_EN_BIT];
  assign xtalPdn  = cfgReg[XTAL_PDN_BIT];

  AST_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> (rdData == $past(wrData))) else $error("readback"); // R8
  AST_STRAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(strapIn) |=> $stable(strapLatch)) else $error("strap moved"); // R3
endmodule

// File: rtl/clkdiv_lane.sv
module clkdiv_lane #(
  parameter int SHIFT_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [SHIFT_W-1:0] reqShift,
  output logic               clkOut
);
  localparam int MAX_SHIFT = (1 << SHIFT_W) - 1;
  localparam int CNT_W     = (MAX_SHIFT > 1) ? MAX_SHIFT - 1 : 1;

  logic [SHIFT_W-1:0] actShift;
  logic [CNT_W-1:0]   cnt;
  logic [CNT_W-1:0]   halfM1;
  logic               q;
  logic               boundary;

  function automatic logic [CNT_W-1:0] halfMinusOne(input logic [SHIFT_W-1:0] s);
    logic [CNT_W:0] h;
    h = '0;
    if (s != '0) h = (CNT_W+1)'(1) << (s - SHIFT_W'(1));
    return (s == '0) ? '0 : CNT_W'(h - 1'b1);
  endfunction

  assign halfM1   = halfMinusOne(actShift);
  // a period ends on passthrough every cycle, else at the end of the low half
  assign boundary = (actShift == '0) || ((cnt == halfM1) && !q);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actShift <= '0;
      cnt      <= '0;
      q        <= 1'b0;
    end else if (boundary) begin
      actShift <= reqShift;
      cnt      <= '0;
      q        <= (reqShift != '0);
    end else if (cnt == halfM1) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end

  assign clkOut = (actShift == '0) ? clk : q;

  AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !boundary |=> (actShift == $past(actShift))) else $error("ratio mid-period"); // R10
  AST_RISE_STARTS_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    ((actShift != '0) && $rose(q)) |-> (cnt == '0)) else $error("rise off boundary"); // R9
endmodule

// File: rtl/clkdiv_datapath.sv
module clkdiv_datapath
  import clkdiv_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  laneReq_t laneReq,
  output logic     sysClkOut,
  output logic     pwmClkOut
);
  logic [SHIFT_W-1:0] reqArr [LANES];
  logic [LANES-1:0]   laneClk;

  assign reqArr[0] = laneReq.sysShift;
  assign reqArr[1] = laneReq.pwmShift;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    clkdiv_lane #(.SHIFT_W(SHIFT_W)) uLane (
      .clk     (clk),
      .rstN    (rstN),
      .reqShift(reqArr[g]),
      .clkOut  (laneClk[g])
    );
  end

  assign sysClkOut = laneClk[0] & laneReq.sysGate;
  assign pwmClkOut = laneClk[1];
endmodule

// File: rtl/dual_clk_divider.sv
module dual_clk_divider
  import clkdiv_pkg::*;
(
  input  logic             mclk,
  input  logic             rstN,
  input  logic             strapIn,
  input  logic             wrEn,
  input  logic [REG_W-1:0] wrData,
  output logic [REG_W-1:0] rdData,
  output logic             sysClkOut,
  output logic             pwmClkOut,
  output logic             sysDrvEn,
  output logic             xtalPdn
);
  laneReq_t laneReq;

  clkdiv_ctrl uCtrl (
    .clk     (mclk),
    .rstN    (rstN),
    .strapIn (strapIn),
    .wrEn    (wrEn),
    .wrData  (wrData),
    .rdData  (rdData),
    .laneReq (laneReq),
    .sysDrvEn(sysDrvEn),
    .xtalPdn (xtalPdn)
  );

  clkdiv_datapath uData (
    .clk      (mclk),
    .rstN     (rstN),
    .laneReq  (laneReq),
    .sysClkOut(sysClkOut),
    .pwmClkOut(pwmClkOut)
  );

  AST_GATE_LOW: assert property (@(negedge mclk) disable iff (!rstN)
    !rdData[SYS_EN_BIT] |-> !sysClkOut) else $error("gate"); // R5
  AST_PDN_PIN: assert property (@(posedge mclk) disable iff (!rstN)
    xtalPdn == rdData[XTAL_PDN_BIT]) else $error("pdn"); // R7
endmodule

// File: tb/dual_clk_divider_test.sv
module dual_clk_divider_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic strapIn = 1'b0;
  logic wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic sysClkOut, pwmClkOut, sysDrvEn, xtalPdn;

  always #2.5 clk = ~clk;

  dual_clk_divider uut (
    .mclk(clk), .rstN(rstN), .strapIn(strapIn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .sysClkOut(sysClkOut), .pwmClkOut(pwmClkOut),
    .sysDrvEn(sysDrvEn), .xtalPdn(xtalPdn)
  );

  int total = 0;
  int fails = 0;
  bit done = 1'b0;
  bit chkOn = 1'b0;
  string curTag = "R11";

  // reference model
  int   mCur [2];
  int   mPos [2];
  logic [7:0] mReg = 8'h80;
  logic mStrap = 1'b0;

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic stepLane(input int i, input int req);
    if (mCur[i] == 0 || mPos[i] == (1 << mCur[i]) - 1) begin
      mCur[i] = req;
      mPos[i] = 0;
    end else begin
      mPos[i]++;
    end
  endtask

  function automatic logic expHigh(input int i);
    return (mCur[i] == 0) ? 1'b1 : (mPos[i] < ((1 << mCur[i]) / 2));
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mCur[0] = 0; mCur[1] = 0; mPos[0] = 0; mPos[1] = 0;
      mReg = 8'h80;
    end else begin
      stepLane(0, (mReg[6:5] == 2'b00) ? int'(mStrap) : int'(mReg[6:5]));
      stepLane(1, int'(mReg[4:3]));
      if (wrEn) mReg = wrData;
      if (chkOn) begin
        #1;
        check(curTag, {7'b0, sysClkOut}, {7'b0, expHigh(0) & mReg[7]});
        check(curTag, {7'b0, pwmClkOut}, {7'b0, expHigh(1)});
      end
    end
  end

  task automatic doReset(input logic s);
    @(negedge clk);
    chkOn = 1'b0;
    rstN = 1'b0;
    strapIn = s;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    mStrap = s;
    @(negedge clk);
    chkOn = 1'b1;
  endtask

  task automatic writeReg(input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1;
    wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
    check("R8", rdData, d);
  endtask

  initial begin
    void'($urandom(32'd4242));
    // reset state
    doReset(1'b0);
    check("R6", rdData, 8'h80);
    check("R6", {7'b0, sysDrvEn}, 8'h01);
    check("R6", {7'b0, xtalPdn}, 8'h00);
    curTag = "R11";
    repeat (12) @(negedge clk);
    // strap pin moves after capture: still ratio 1
    curTag = "R3";
    strapIn = 1'b1;
    repeat (12) @(negedge clk);
    // strap high at reset gives ratio 2
    doReset(1'b1);
    curTag = "R2";
    repeat (12) @(negedge clk);
    strapIn = 1'b0;
    curTag = "R3";
    repeat (12) @(negedge clk);
    // explicit system ratios with each PWM ratio
    curTag = "R1";
    writeReg(8'hA0); repeat (20) @(negedge clk);
    writeReg(8'hC8); repeat (30) @(negedge clk);
    curTag = "R4";
    writeReg(8'hF0); repeat (40) @(negedge clk);
    writeReg(8'hF8); repeat (40) @(negedge clk);
    curTag = "R9";
    writeReg(8'hC0); repeat (40) @(negedge clk);
    // driver enable off
    curTag = "R5";
    writeReg(8'h60);
    check("R5", {7'b0, sysDrvEn}, 8'h00);
    repeat (24) @(negedge clk);
    writeReg(8'hE3);
    check("R5", {7'b0, sysDrvEn}, 8'h01);
    // power-down flag
    writeReg(8'h84);
    check("R7", {7'b0, xtalPdn}, 8'h01);
    writeReg(8'h80);
    check("R7", {7'b0, xtalPdn}, 8'h00);
    // random reprogramming at any phase
    curTag = "R10";
    for (int k = 0; k < 60; k++) begin
      writeReg(8'($urandom));
      repeat ($urandom_range(0, 17)) @(negedge clk);
    end
    // back-to-back writes
    writeReg(8'hE0);
    writeReg(8'hB8);
    writeReg(8'h90);
    repeat (30) @(negedge clk);
    chkOn = 1'b0;
    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule